// File: doc/BRIEF.md
# Peripheral Register Bus Bridge

This bridge sits between a CPU data port and a bank of 16-bit memory-mapped peripheral registers. It claims every CPU request whose 24-bit address falls in the 4 KB window `FFF000h`–`FFFFFFh`. Only 1 KB of registers physically exists, so the same registers appear four times across the window. The bridge turns byte, halfword and word requests into accesses on a register port that only moves halfwords. A word request becomes two halfword operations issued back to back.

A register attribute rule marks every register as defined or undefined, and as byte-only or halfword-wide. The bridge uses it to choose byte lanes and to suppress accesses to undefined offsets. Instruction fetches aimed at the window get an error response and never reach the registers. Requests outside the window are left alone, so another responder on the same CPU port can serve them.

Top module: `periph_bridge`

## Requirements
- R1: A request is accepted only when address bits 23:12 equal `FFFh`. Any other address gets no `cpu_ready`, no `cpu_err` and no register operation.
- R2: Address bits 11:10 are ignored. The register index driven on `reg_addr` is address bits 9:1, so `FFF440h` and `FFFC40h` reach the same register as `FFF040h`.
- R3: Address bit 0 is ignored. A byte request drives `reg_be = 01` and puts the write byte on `reg_wdata[7:0]`. A byte read returns register bits 7:0 on `cpu_rdata[7:0]`, with all higher bits zero.
- R4: Register indices 0–15 (offsets `000h`–`01Fh`) are byte-only. A halfword or word half that targets one of them uses `reg_be = 01`, so only write bits 7:0 are committed. On a read its bits 15:8 are undefined. Indices 16–63 are halfword registers and use `reg_be = 11`.
- R5: A word request to index i issues two halfword operations in order. The first goes to index i and carries data bits 15:0. The second goes to index i+1 (modulo 512) and carries bits 31:16. A word read returns the first halfword in bits 15:0 and the second in bits 31:16.
- R6: A request is accepted on a clock edge in which the bridge is idle. Register operations start the cycle after acceptance, and register read data is taken one cycle after its operation. `cpu_ready` is a single-cycle pulse: 2 cycles after acceptance for byte and halfword requests, 3 cycles after for word requests.
- R7: A fetch request (`cpu_fetch = 1`) inside the window raises `cpu_ready` and `cpu_err` together, 1 cycle after acceptance. `cpu_rdata` is zero and no register operation is issued.
- R8: Indices 64–511 (offsets `080h`–`3FFh`) are undefined. No register operation is issued for them, reads return zero for that halfword, and `cpu_err` stays low.
- R9: During and right after reset, `cpu_ready`, `cpu_err` and `reg_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid |
| cpu_addr | input | 24 | Byte address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wr | input | 1 | 1 write, 0 read |
| cpu_fetch | input | 1 | Request is an instruction fetch |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Completion pulse |
| cpu_err | output | 1 | Error response, with `cpu_ready` |
| reg_en | output | 1 | Register operation strobe |
| reg_addr | output | 9 | Halfword register index |
| reg_we | output | 1 | Register write |
| reg_be | output | 2 | Byte lanes of the operation |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, one cycle after `reg_en` |

## Verification
The bench drives word accesses whose two halves land on different register types: byte-only then halfword, defined then undefined, and a wrap from index 511 to index 0. This shows that each half gets its own lane and decode decision and that the halves are not swapped. Byte writes to odd addresses followed by halfword readbacks show whether bit 0 is dropped and the untouched byte is preserved. Mirrored addresses, fetches inside and outside the window, and addresses just outside the window separate aliasing, error reporting and claiming. Every cycle the register port is compared with the operation list that the bench's own model expects.

// File: rtl/periph_bridge.sv
module periph_bridge #(
  parameter int ADDR_W    = 24,
  parameter int WIN_BITS  = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'hFFF000,
  parameter int PHYS_BITS = 10,
  parameter int NUM_HALF  = 64,
  parameter int BYTE_REGS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic [1:0]             cpu_size,
  input  logic                   cpu_wr,
  input  logic                   cpu_fetch,
  input  logic [31:0]            cpu_wdata,
  output logic [31:0]            cpu_rdata,
  output logic                   cpu_ready,
  output logic                   cpu_err,
  output logic                   reg_en,
  output logic [PHYS_BITS-2:0]   reg_addr,
  output logic                   reg_we,
  output logic [1:0]             reg_be,
  output logic [15:0]            reg_wdata,
  input  logic [15:0]            reg_rdata
);
  localparam int IDX_W = PHYS_BITS - 1;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND, S_DONE} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       size_q;
  logic             wr_q, err_q, f_def, f_nar;
  logic [31:0]      wdata_q;
  logic [15:0]      lo_q;

  function automatic logic [15:0] shape(input logic [15:0] d, input logic def, input logic nar);
    if (!def)     return 16'h0000;
    else if (nar) return {8'h00, d[7:0]};
    else          return d;
  endfunction

  wire hit     = cpu_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS];
  wire is_word = size_q == 2'd2;
  wire cur_def = int'(idx_q) < NUM_HALF;
  wire cur_nar = (size_q == 2'd0) || (int'(idx_q) < BYTE_REGS);
  wire issuing = (st == S_FIRST) || (st == S_SECOND);
  wire [15:0] last_half = shape(reg_rdata, cur_def, cur_nar);

  assign reg_en    = issuing && cur_def;
  assign reg_addr  = idx_q;
  assign reg_we    = wr_q;
  assign reg_be    = cur_nar ? 2'b01 : 2'b11;
  assign reg_wdata = (st == S_SECOND) ? wdata_q[31:16] : wdata_q[15:0];

  assign cpu_ready = st == S_DONE;
  assign cpu_err   = (st == S_DONE) && err_q;
  assign cpu_rdata = (st != S_DONE || wr_q || err_q) ? 32'h0 :
                     is_word ? {last_half, lo_q} : {16'h0000, last_half};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx_q   <= '0;
      size_q  <= 2'd0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      f_def   <= 1'b0;
      f_nar   <= 1'b0;
      wdata_q <= 32'h0;
      lo_q    <= 16'h0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req && hit) begin
          idx_q   <= cpu_addr[PHYS_BITS-1:1];
          size_q  <= cpu_size;
          wr_q    <= cpu_wr;
          err_q   <= cpu_fetch;
          wdata_q <= cpu_wdata;
          st      <= cpu_fetch ? S_DONE : S_FIRST;
        end
        S_FIRST: begin
          f_def <= cur_def;
          f_nar <= cur_nar;
          if (is_word) begin
            idx_q <= idx_q + IDX_W'(1);
            st    <= S_SECOND;
          end else begin
            st <= S_DONE;
          end
        end
        S_SECOND: begin
          lo_q <= shape(reg_rdata, f_def, f_nar);
          st   <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_quiet_reset: assert property (@(posedge clk) $past(!rst_n) |-> !cpu_ready && !cpu_err && !reg_en);
  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n) cpu_ready |=> !cpu_ready);
  a_r7_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_ready && !reg_en && !$past(reg_en));
  a_r5_second_next: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && $past(reg_en) |-> reg_addr == $past(reg_addr) + IDX_W'(1));
  a_r8_undef_silent: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |-> int'(reg_addr) < NUM_HALF);
  a_r4_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && int'(reg_addr) < BYTE_REGS |-> reg_be == 2'b01);
endmodule

// File: tb/periph_bridge_test.sv
module periph_bridge_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_wr = 0, cpu_fetch = 0;
  logic [23:0] cpu_addr = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, cpu_err, reg_en, reg_we;
  logic [8:0]  reg_addr;
  logic [1:0]  reg_be;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata = '0;
  logic [15:0] per_mem [512];
  logic [15:0] ref_mem [512];
  int tests = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  periph_bridge uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_wr(cpu_wr), .cpu_fetch(cpu_fetch), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .cpu_err(cpu_err), .reg_en(reg_en), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always @(posedge clk) begin
    if (reg_en) begin
      if (reg_we) begin
        if (reg_be[0]) per_mem[reg_addr][7:0]  <= reg_wdata[7:0];
        if (reg_be[1]) per_mem[reg_addr][15:8] <= reg_wdata[15:8];
      end else begin
        reg_rdata <= per_mem[reg_addr];
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic txn(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                     input logic fe, input logic [31:0] wd, input string tag);
    logic [31:0] exp_rd = 32'h0, care = 32'h0;
    int nops = (sz == 2'd2) ? 2 : 1;
    if (a[23:12] != 12'hFFF) begin
      @(negedge clk);
      cpu_req = 1; cpu_addr = a; cpu_size = sz; cpu_wr = wr; cpu_fetch = fe; cpu_wdata = wd;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(!cpu_ready && !cpu_err && !reg_en, "R1", {tag, " outside window ignored"},
            {29'h0, cpu_ready, cpu_err, reg_en}, 32'h0);
      end
      cpu_req = 0;
      return;
    end
    @(negedge clk);
    cpu_req = 1; cpu_addr = a; cpu_size = sz; cpu_wr = wr; cpu_fetch = fe; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    if (fe) begin
      chk(cpu_ready && cpu_err && !reg_en && cpu_rdata == 0, "R7", {tag, " fetch error"},
          {cpu_rdata[28:0], cpu_ready, cpu_err, reg_en}, 32'h6);
      @(negedge clk);
      chk(!cpu_ready && !cpu_err, "R6", {tag, " ready drops"}, {30'h0, cpu_ready, cpu_err}, 32'h0);
      return;
    end
    for (int k = 0; k < nops; k++) begin
      logic [8:0] idx = a[9:1] + 9'(k);
      bit def = idx < 64;
      bit bon = idx < 16;
      bit nar = (sz == 2'd0) || bon;
      logic [1:0]  be = nar ? 2'b01 : 2'b11;
      logic [15:0] d = (k == 1) ? wd[31:16] : wd[15:0];
      logic [15:0] hv = !def ? 16'h0 : nar ? {8'h00, ref_mem[idx][7:0]} : ref_mem[idx];
      logic [15:0] hc = (bon && sz != 2'd0) ? 16'h00FF : 16'hFFFF;
      chk(reg_en == def, def ? "R5" : "R8", {tag, " reg_en"}, {31'h0, reg_en}, {31'h0, def});
      if (def && reg_en) begin
        chk(reg_addr == idx, "R2", {tag, " reg_addr"}, {23'h0, reg_addr}, {23'h0, idx});
        chk(reg_we == wr && reg_be == be, "R4", {tag, " we/be"},
            {29'h0, reg_we, reg_be}, {29'h0, wr, be});
        if (wr) chk(reg_wdata == d, "R3", {tag, " wdata"}, {16'h0, reg_wdata}, {16'h0, d});
      end
      if (wr && def) begin
        ref_mem[idx][7:0] = d[7:0];
        if (!nar) ref_mem[idx][15:8] = d[15:8];
      end
      if (k == 0) begin exp_rd[15:0] = hv; care[15:0] = hc; end
      else begin exp_rd[31:16] = hv; care[31:16] = hc; end
      @(negedge clk);
    end
    if (nops == 1) care[31:16] = 16'hFFFF;
    chk(cpu_ready && !cpu_err, "R6", {tag, " ready"}, {30'h0, cpu_ready, cpu_err}, 32'h2);
    if (!wr) chk((cpu_rdata & care) == (exp_rd & care), "R5", {tag, " read data"},
                 cpu_rdata & care, exp_rd & care);
    @(negedge clk);
    chk(!cpu_ready, "R6", {tag, " single pulse"}, {31'h0, cpu_ready}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      per_mem[i] = 16'hA500 ^ 16'(i * 7);
      ref_mem[i] = 16'hA500 ^ 16'(i * 7);
    end
    repeat (3) @(negedge clk);
    chk(!cpu_ready && !cpu_err && !reg_en, "R9", "reset outputs",
        {29'h0, cpu_ready, cpu_err, reg_en}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk(!cpu_ready && !cpu_err && !reg_en, "R9", "after reset",
        {29'h0, cpu_ready, cpu_err, reg_en}, 32'h0);

    txn(24'hFFEFFE, 2'd1, 1'b0, 1'b0, 32'h0, "R1 below");
    txn(24'h000100, 2'd2, 1'b1, 1'b0, 32'hDEADBEEF, "R1 low addr");
    txn(24'h123040, 2'd1, 1'b0, 1'b1, 32'h0, "R1 fetch outside");
    txn(24'hFFF040, 2'd2, 1'b1, 1'b0, 32'h12345678, "R5 word write");
    txn(24'hFFF040, 2'd2, 1'b0, 1'b0, 32'h0, "R5 word read");
    txn(24'hFFF440, 2'd2, 1'b0, 1'b0, 32'h0, "R2 alias 400");
    txn(24'hFFFC42, 2'd1, 1'b0, 1'b0, 32'h0, "R2 alias C00");
    txn(24'hFFF051, 2'd0, 1'b1, 1'b0, 32'h0000005A, "R3 odd byte write");
    txn(24'hFFF050, 2'd1, 1'b0, 1'b0, 32'h0, "R3 halfword readback");
    txn(24'hFFF051, 2'd0, 1'b0, 1'b0, 32'h0, "R3 odd byte read");
    txn(24'hFFF004, 2'd1, 1'b1, 1'b0, 32'h00001234, "R4 byte-only hw write");
    txn(24'hFFF005, 2'd0, 1'b0, 1'b0, 32'h0, "R4 byte-only read");
    txn(24'hFFF01E, 2'd2, 1'b1, 1'b0, 32'hCAFEF00D, "R4 mixed word write");
    txn(24'hFFF01E, 2'd2, 1'b0, 1'b0, 32'h0, "R4 mixed word read");
    txn(24'hFFF100, 2'd1, 1'b1, 1'b0, 32'h0000BEEF, "R8 undefined write");
    txn(24'hFFF100, 2'd1, 1'b0, 1'b0, 32'h0, "R8 undefined read");
    txn(24'hFFF07E, 2'd2, 1'b0, 1'b0, 32'h0, "R8 half-defined word");
    txn(24'hFFF3FE, 2'd2, 1'b1, 1'b0, 32'h77665544, "R5 wrap write");
    txn(24'hFFF000, 2'd1, 1'b0, 1'b0, 32'h0, "R5 wrap readback");
    txn(24'hFFF040, 2'd2, 1'b0, 1'b1, 32'h0, "R7 fetch in window");
    txn(24'hFFFFFE, 2'd1, 1'b0, 1'b1, 32'h0, "R7 fetch top");
    txn(24'hFFF020, 2'd1, 1'b1, 1'b0, 32'h0000ABCD, "R4 halfword reg write");
    txn(24'hFFF020, 2'd1, 1'b0, 1'b0, 32'h0, "R4 halfword reg read");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule